// File: doc/BRIEF.md
# Refresh Row Address Generator

This block sits beside a processor core and supplies the row addresses that keep a dynamic memory alive. Whenever the core enters an instruction-decode phase in which it has no use for the address bus, the block raises a one-cycle refresh strobe. In that same cycle it presents the current refresh row on its address output. After each refresh the row advances, so successive decode phases walk through the memory's rows.

The automatic advance covers only the seven low bits, which gives 128 rows and wraps from 127 back to 0. The top bit belongs to software: a register write loads all eight bits, and the advance never alters bit 7. Memories with 256 rows cannot rely on that register alone. For them the block also carries a separate eight-bit extension counter, which steps once per strobe and provides a full row address on its own output.

Top module: `rfsh_addr_gen`

## Requirements
- R1: While reset (active-low `rstN`) is asserted, and in the first cycle after it with `decodeIdle` low, `rfshStrobe` is 0 and both `rfshAddr` and `extRow` are 0. The refresh register and the extension counter both restart from 0.
- R2: `rfshStrobe` is 1 for exactly one cycle per decode phase. It rises combinationally in the first cycle that `decodeIdle` is high after a cycle in which it was low, and it stays 0 for the rest of that phase.
- R3: During a strobe cycle `rfshAddr` equals the full 8-bit refresh register. In every other cycle it is 0.
- R4: After each strobe, bits [6:0] of the register increase by one, wrapping from 127 to 0.
- R5: The automatic increment never changes bit 7 of the register.
- R6: A write (`wrEn`=1) loads all 8 bits of `wrData` into the register at the clock edge. The next strobe presents the written value.
- R7: If a write and a strobe fall in the same cycle, that strobe still shows the old value. The write wins over the increment, so the following strobe presents exactly the written value.
- R8: During a strobe `extRow` shows the 8-bit extension counter, and in other cycles it is 0. The counter steps by one per strobe, wraps from 255 to 0, and is not affected by writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| decodeIdle | input | 1 | High while the core is in a bus-idle decode phase |
| wrEn | input | 1 | Software write strobe for the refresh register |
| wrData | input | 8 | Value to load on a write |
| rfshStrobe | output | 1 | One-cycle refresh strobe |
| rfshAddr | output | 8 | Refresh register on the address bus (0 outside a strobe) |
| extRow | output | 8 | Extension counter row (0 outside a strobe) |

## Verification
The bench holds `decodeIdle` high for several cycles to expose a strobe that repeats for the whole phase instead of firing once. It drives a write in the same cycle as a strobe. An increment that wins over that write would show the written value plus one at the next refresh. Writes of 0xFF and 0x7F check the wrap: carrying into bit 7 would turn 0x80 into 0x00, or 0x00 into 0x80. A run of 256+ refreshes checks that the extension counter wraps and ignores writes, and a mid-run reset checks that both counters restart from zero.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  // Strobes sent from the control block to the datapath
  typedef struct packed {
    logic refresh;  // refresh cycle in progress
    logic load;     // software write of the register
  } rfshCtl_t;
endpackage

// File: rtl/rfsh_ctrl.sv
module rfsh_ctrl
  import rfsh_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     decodeIdle,
  input  logic     wrEn,
  output rfshCtl_t ctl
);
  logic prevIdle;

  // Remember the phase input so that only its first cycle produces a strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevIdle <= 1'b0;
    else       prevIdle <= decodeIdle;
  end

  always_comb begin
    ctl.refresh = decodeIdle & ~prevIdle & rstN;
    ctl.load    = wrEn & rstN;
  end
endmodule

// File: rtl/rfsh_datapath.sv
module rfsh_datapath
  import rfsh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LOW_W  = 7,
  parameter int EXT_W  = 8,
  parameter bit EXT_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  rfshCtl_t          ctl,
  input  logic [ADDR_W-1:0] wrData,
  output logic [ADDR_W-1:0] rfshAddr,
  output logic [EXT_W-1:0]  extRow
);
  localparam int HIGH_W = ADDR_W - LOW_W;

  logic [ADDR_W-1:0] rowReg;
  logic [LOW_W-1:0]  lowNext;
  logic [ADDR_W-1:0] stepped;

  // Only the low field advances; the high field is carried through unchanged
  always_comb begin
    lowNext = rowReg[LOW_W-1:0] + {{(LOW_W-1){1'b0}}, 1'b1};
    stepped = {rowReg[ADDR_W-1 -: HIGH_W], lowNext};
  end

  // A write takes precedence over the increment
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rowReg <= '0;
    else if (ctl.load)    rowReg <= wrData;
    else if (ctl.refresh) rowReg <= stepped;
  end

  assign rfshAddr = ctl.refresh ? rowReg : '0;

  generate
    if (EXT_EN) begin : g_ext
      logic [EXT_W-1:0] extCnt;
      // Counter advanced by the strobe alone; writes do not touch it
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            extCnt <= '0;
        else if (ctl.refresh) extCnt <= extCnt + {{(EXT_W-1){1'b0}}, 1'b1};
      end
      assign extRow = ctl.refresh ? extCnt : '0;
    end else begin : g_noext
      // Without the extension, the register itself is presented
      always_comb begin
        extRow = '0;
        if (ctl.refresh) extRow[ADDR_W-1:0] = rowReg;
      end
    end
  endgenerate
endmodule

// File: rtl/rfsh_addr_gen.sv
module rfsh_addr_gen
  import rfsh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LOW_W  = 7,
  parameter int EXT_W  = 8,
  parameter bit EXT_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              decodeIdle,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrData,
  output logic              rfshStrobe,
  output logic [ADDR_W-1:0] rfshAddr,
  output logic [EXT_W-1:0]  extRow
);
  rfshCtl_t ctl;

  rfsh_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .decodeIdle (decodeIdle),
    .wrEn       (wrEn),
    .ctl        (ctl)
  );

  rfsh_datapath #(
    .ADDR_W (ADDR_W),
    .LOW_W  (LOW_W),
    .EXT_W  (EXT_W),
    .EXT_EN (EXT_EN)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .wrData   (wrData),
    .rfshAddr (rfshAddr),
    .extRow   (extRow)
  );

  assign rfshStrobe = ctl.refresh;
endmodule

// File: rtl/rfsh_addr_chk.sv
module rfsh_addr_chk #(
  parameter int ADDR_W = 8,
  parameter int LOW_W  = 7,
  parameter int EXT_W  = 8,
  parameter bit EXT_EN = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic              decodeIdle,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrData,
  input logic              rfshStrobe,
  input logic [ADDR_W-1:0] rfshAddr,
  input logic [EXT_W-1:0]  extRow
);
  logic              seenRef;
  logic              wrPend;
  logic [ADDR_W-1:0] lastAddr;
  logic [ADDR_W-1:0] lastWr;
  logic [EXT_W-1:0]  lastExt;
  logic [LOW_W-1:0]  lowExp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenRef  <= 1'b0;
      wrPend   <= 1'b0;
      lastAddr <= '0;
      lastWr   <= '0;
      lastExt  <= '0;
    end else begin
      if (rfshStrobe) begin
        seenRef  <= 1'b1;
        wrPend   <= 1'b0;
        lastAddr <= rfshAddr;
        lastExt  <= extRow;
      end
      if (wrEn) begin
        wrPend <= 1'b1;
        lastWr <= wrData;
      end
    end
  end

  assign lowExp = lastAddr[LOW_W-1:0] + {{(LOW_W-1){1'b0}}, 1'b1};

  p_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    rfshStrobe |=> !rfshStrobe);
  p_in_phase_r2: assert property (@(posedge clk) disable iff (!rstN)
    rfshStrobe |-> decodeIdle);
  p_addr_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    !rfshStrobe |-> (rfshAddr == '0 && extRow == '0));
  p_low_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rfshStrobe && seenRef && !wrPend) |-> (rfshAddr[LOW_W-1:0] == lowExp));
  p_top_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rfshStrobe && seenRef && !wrPend) |->
      (rfshAddr[ADDR_W-1:LOW_W] == lastAddr[ADDR_W-1:LOW_W]));
  p_write_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rfshStrobe && wrPend) |-> (rfshAddr == lastWr));
  p_ext_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (EXT_EN && rfshStrobe && seenRef) |->
      (extRow == lastExt + {{(EXT_W-1){1'b0}}, 1'b1}));
endmodule

bind rfsh_addr_gen rfsh_addr_chk #(
  .ADDR_W (ADDR_W),
  .LOW_W  (LOW_W),
  .EXT_W  (EXT_W),
  .EXT_EN (EXT_EN)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .decodeIdle (decodeIdle),
  .wrEn       (wrEn),
  .wrData     (wrData),
  .rfshStrobe (rfshStrobe),
  .rfshAddr   (rfshAddr),
  .extRow     (extRow)
);

// File: tb/rfsh_addr_gen_tb.sv
`timescale 1ns/1ps
module rfsh_addr_gen_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       decodeIdle = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       rfshStrobe;
  logic [7:0] rfshAddr;
  logic [7:0] extRow;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  rfsh_addr_gen u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .decodeIdle (decodeIdle),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .rfshStrobe (rfshStrobe),
    .rfshAddr   (rfshAddr),
    .extRow     (extRow)
  );

  // Bench model built from the requirements
  logic [7:0] mReg, mExt;
  logic       mPrev;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Vector: idle, we, wd[7:0], strobe, addr[7:0], ext[7:0]
  localparam int NV = 10;
  localparam logic [26:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'h00, 1'b1, 8'h00, 8'h00},
    {1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00},
    {1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00},
    {1'b1, 1'b0, 8'h00, 1'b1, 8'h01, 8'h01},
    {1'b0, 1'b1, 8'h85, 1'b0, 8'h00, 8'h00},
    {1'b1, 1'b0, 8'h00, 1'b1, 8'h85, 8'h02},
    {1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00},
    {1'b1, 1'b1, 8'h10, 1'b1, 8'h86, 8'h03},
    {1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 8'h00},
    {1'b1, 1'b0, 8'h00, 1'b1, 8'h10, 8'h04}
  };

  // One model-checked cycle: drive, sample, then advance the model
  task automatic cyc(input logic idle, input logic we, input logic [7:0] wd, input string tag);
    logic stb;
    @(negedge clk);
    decodeIdle = idle; wrEn = we; wrData = wd;
    #1;
    stb = idle & ~mPrev;
    check({tag, " R2 strobe"}, {7'd0, rfshStrobe}, {7'd0, stb});
    check({tag, " R3 addr"}, rfshAddr, stb ? mReg : 8'h00);
    check({tag, " R8 ext"}, extRow, stb ? mExt : 8'h00);
    if (stb) mExt = mExt + 8'd1;
    if (we) mReg = wd;
    else if (stb) mReg = {mReg[7], mReg[6:0] + 7'd1};
    mPrev = idle;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; decodeIdle = 1'b0; wrEn = 1'b0; wrData = '0;
    #1;
    check("R1 strobe in reset", {7'd0, rfshStrobe}, 8'h00);
    check("R1 addr in reset", rfshAddr, 8'h00);
    check("R1 ext in reset", extRow, 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    mReg = '0; mExt = '0; mPrev = 1'b0;
  endtask

  initial begin
    mReg = '0; mExt = '0; mPrev = 1'b0;
    doReset();

    // Table walk (R2, R3, R4, R6, R7, R8)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      decodeIdle = VEC[i][26]; wrEn = VEC[i][25]; wrData = VEC[i][24:17];
      #1;
      check($sformatf("vec%0d R2 strobe", i), {7'd0, rfshStrobe}, {7'd0, VEC[i][16]});
      check($sformatf("vec%0d R3/R7 addr", i), rfshAddr, VEC[i][15:8]);
      check($sformatf("vec%0d R8 ext", i), extRow, VEC[i][7:0]);
    end

    doReset();
    // R1: first refresh after reset presents zeros
    cyc(1'b1, 1'b0, 8'h00, "R1 first");
    // R2: long phase gives a single strobe
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 8'h00, "R2 long phase");
    cyc(1'b0, 1'b0, 8'h00, "gap");
    // R5: 0xFF wraps to 0x80, bit 7 kept
    cyc(1'b0, 1'b1, 8'hFF, "R6 write FF");
    cyc(1'b1, 1'b0, 8'h00, "R6 show FF");
    cyc(1'b0, 1'b0, 8'h00, "gap");
    @(negedge clk); decodeIdle = 1'b1; wrEn = 1'b0; #1;
    check("R5 bit7 held after wrap", rfshAddr, 8'h80);
    mReg = {mReg[7], mReg[6:0] + 7'd1}; mExt = mExt + 8'd1; mPrev = 1'b1;
    cyc(1'b0, 1'b0, 8'h00, "gap");
    // R4: 0x7F wraps to 0x00 without carry into bit 7
    cyc(1'b0, 1'b1, 8'h7F, "R6 write 7F");
    cyc(1'b1, 1'b0, 8'h00, "R4 show 7F");
    cyc(1'b0, 1'b0, 8'h00, "gap");
    @(negedge clk); decodeIdle = 1'b1; #1;
    check("R4 low wrap to 00", rfshAddr, 8'h00);
    mReg = {mReg[7], mReg[6:0] + 7'd1}; mExt = mExt + 8'd1; mPrev = 1'b1;
    cyc(1'b0, 1'b0, 8'h00, "gap");
    // R7: write during strobe, then R8 extension wrap with writes mixed in
    cyc(1'b1, 1'b1, 8'h42, "R7 collide");
    cyc(1'b0, 1'b0, 8'h00, "gap");
    cyc(1'b1, 1'b0, 8'h00, "R7 written value");
    for (int i = 0; i < 260; i++) begin
      cyc(1'b0, (i % 37) == 0, 8'(i), "R8 wrap low");
      cyc(1'b1, 1'b0, 8'h00, "R8 wrap");
    end
    // R1: reset mid-run restarts both counters
    doReset();
    cyc(1'b1, 1'b0, 8'h00, "R1 restart");
    cyc(1'b0, 1'b0, 8'h00, "gap");
    cyc(1'b1, 1'b0, 8'h00, "R1 restart second");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule